// File: doc/BRIEF.md
# Synthesizer Control Register with Power-Down Sequencer

This block receives 24-bit configuration words over a three-wire serial port (serial clock, serial data, load strobe) and applies the settings for a frequency synthesizer. Each word is shifted in most-significant bit first. It is committed when the load strobe rises. The two lowest bits of the word are a target address. Only address 00, the control register, is acted on here. Words with any other address leave every output unchanged.

From the committed control word, the block derives these outputs:
- the charge-pump current code, with a gain bit choosing between two current settings;
- a charge-pump three-state request;
- a counter hold;
- a lock-detect reset;
- the RF output enable, with an optional mute that keeps RF off until lock.

The power-down field has three behaviours:
- An immediate power-down takes effect on the clock after the strobe.
- A synchronous power-down waits for the second rising edge of an external reference-counter pulse.
- Clearing the power-down bit cancels either kind.

A low chip-enable pin powers the block down at once, regardless of the register contents. Every serial input is sampled on the system clock `clk`, and edges are detected in that domain.

Top module: `synth_ctl_latch`

## Requirements
- R1: Data is shifted in MSB first, one bit per rising edge of `sclk_i`. The register keeps only the last 24 bits. The rising edge of `le_i` commits those 24 bits, and the outputs reflect them from the next `clk` edge.
- R2: A word is applied only when its bits [1:0] are 00. A word with address 01, 10 or 11 changes no output.
- R3: A committed word with bit 20 = 1 and bit 21 = 0 asserts `pd_active_o` starting at the `clk` edge that sees the strobe.
- R4: A committed word with bit 20 = 1 and bit 21 = 1 arms a synchronous power-down. `pd_active_o` rises at the `clk` edge that sees the second rising edge of `ref_pulse_i` after the strobe. A new arming word restarts the edge count.
- R5: A committed word with bit 20 = 0 cancels a pending synchronous power-down. It also clears `pd_active_o` at the `clk` edge that sees the strobe.
- R6: While `ce_i` is low, `pd_active_o` is high and `rf_en_o` is low, whatever the register holds.
- R7: While `pd_active_o` is high, `cnt_hold_o`, `cp_tristate_o` and `ld_reset_o` are high, and `rf_en_o` is low.
- R8: The serial port keeps accepting and committing words while the block is powered down.
- R9: `cp_cur_o` equals bits [19:17] when bit 10 = 1, and bits [16:14] when bit 10 = 0.
- R10: Bit 4 = 1 drives `cnt_hold_o` high even when the block is not powered down.
- R11: Bit 11 = 1 keeps `rf_en_o` low until `lock_det_i` is high.
- R12: Bit 3 = 1 drives `cp_tristate_o` high, independent of the power-down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, sampled on clk |
| sdata_i | input | 1 | Serial data |
| le_i | input | 1 | Load strobe; its rising edge commits the word |
| ce_i | input | 1 | Chip enable; low forces power-down |
| ref_pulse_i | input | 1 | Reference-counter output pulse |
| lock_det_i | input | 1 | Lock-detect indication |
| pd_active_o | output | 1 | Block powered down |
| cnt_hold_o | output | 1 | Hold counters in load/reset state |
| cp_tristate_o | output | 1 | Charge pump three-state request |
| ld_reset_o | output | 1 | Lock-detect reset |
| rf_en_o | output | 1 | RF output enable |
| cp_cur_o | output | 3 | Selected charge-pump current code |

## Verification
The bench sweeps every pair of current codes under both gain values. It feeds in more than 24 bits before a strobe, to catch a design that keeps the wrong bits or shifts in the wrong order. It probes the synchronous power-down after exactly one reference edge and after two, and again after a re-arming word. A design that counts the edge seen in the strobe cycle, that powers down on the first edge, or that fails to restart the count would show `pd_active_o` one edge early or late. It also writes words with non-zero addresses, loads words while powered down, and cancels an armed power-down. A design that decodes the address loosely, freezes the port during power-down, or keeps a stale pending request would show stale current codes or a late power-down.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int WORD_W   = 24;
    localparam int ADDR_W   = 2;
    localparam int CUR_W    = 3;
    localparam int BIT_TRI  = 3;
    localparam int BIT_CRST = 4;
    localparam int BIT_GAIN = 10;
    localparam int BIT_MUTE = 11;
    localparam int CUR1_LSB = 14;
    localparam int CUR2_LSB = CUR1_LSB + CUR_W;
    localparam int BIT_PD1  = 20;
    localparam int BIT_PD2  = 21;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic             pd2;
        logic             pd1;
        logic [CUR_W-1:0] cur2;
        logic [CUR_W-1:0] cur1;
        logic             mute;
        logic             gain;
        logic             crst;
        logic             tri3;
    } ctl_t;

    typedef enum logic [1:0] {
        PD_RUN   = 2'd0,
        PD_ARMED = 2'd1,
        PD_DOWN  = 2'd2
    } pd_state_t;

    function automatic logic is_ctl_addr(word_t w);
        return w[ADDR_W-1:0] == '0;
    endfunction

    function automatic ctl_t decode(word_t w);
        ctl_t c;
        c.pd2  = w[BIT_PD2];
        c.pd1  = w[BIT_PD1];
        c.cur2 = w[CUR2_LSB +: CUR_W];
        c.cur1 = w[CUR1_LSB +: CUR_W];
        c.mute = w[BIT_MUTE];
        c.gain = w[BIT_GAIN];
        c.crst = w[BIT_CRST];
        c.tri3 = w[BIT_TRI];
        return c;
    endfunction
endpackage

// File: rtl/sctl_serial_in.sv
module sctl_serial_in
    import sctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic sdata_i,
    input  logic le_i,
    output logic load_o,
    output ctl_t ctl_o
);
    word_t sr_q;
    logic  sclk_q;
    logic  le_q;
    logic  sclk_rise;
    logic  le_rise;

    assign sclk_rise = sclk_i & ~sclk_q;
    assign le_rise   = le_i & ~le_q;
    assign load_o    = le_rise & is_ctl_addr(sr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
            ctl_o  <= '0;
        end else begin
            sclk_q <= sclk_i;
            le_q   <= le_i;
            if (sclk_rise)
                sr_q <= {sr_q[WORD_W-2:0], sdata_i};
            if (load_o)
                ctl_o <= decode(sr_q);
        end
    end

    AST_ADDR_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (le_rise && !is_ctl_addr(sr_q)) |=> $stable(ctl_o)) else $error("addr"); // R2
endmodule

// File: rtl/sctl_pd_seq.sv
module sctl_pd_seq
    import sctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  ctl_t ctl_i,
    input  ctl_t next_ctl_i,
    input  logic ref_pulse_i,
    output logic down_o
);
    pd_state_t state_q;
    logic      ref_q;
    logic      seen_q;
    logic      ref_rise;

    assign ref_rise = ref_pulse_i & ~ref_q;
    assign down_o   = (state_q == PD_DOWN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PD_RUN;
            ref_q   <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            ref_q <= ref_pulse_i;
            if (load_i) begin
                seen_q <= 1'b0;
                if (!next_ctl_i.pd1)
                    state_q <= PD_RUN;
                else if (!next_ctl_i.pd2)
                    state_q <= PD_DOWN;
                else if (state_q != PD_DOWN)
                    state_q <= PD_ARMED;
            end else if (state_q == PD_ARMED && ref_rise) begin
                if (seen_q)
                    state_q <= PD_DOWN;
                else
                    seen_q <= 1'b1;
            end
        end
    end

    AST_ASYNC_DOWN: assert property (@(posedge clk) disable iff (rst)
        (load_i && next_ctl_i.pd1 && !next_ctl_i.pd2) |=> down_o) else $error("async"); // R3
    AST_SYNC_EARLY: assert property (@(posedge clk) disable iff (rst)
        (state_q == PD_ARMED && !load_i && !ref_rise) |=> !down_o) else $error("early"); // R4
    AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (load_i && !next_ctl_i.pd1) |=> !down_o) else $error("cancel"); // R5
    AST_DOWN_NEEDS_PD1: assert property (@(posedge clk) disable iff (rst)
        down_o |-> ctl_i.pd1) else $error("pd1"); // R5
endmodule

// File: rtl/sctl_drive.sv
module sctl_drive
    import sctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_i,
    input  logic             down_i,
    input  ctl_t             ctl_i,
    input  logic             lock_det_i,
    output logic             pd_active_o,
    output logic             cnt_hold_o,
    output logic             cp_tristate_o,
    output logic             ld_reset_o,
    output logic             rf_en_o,
    output logic [CUR_W-1:0] cp_cur_o
);
    always_comb begin
        pd_active_o   = down_i | ~ce_i;
        cnt_hold_o    = pd_active_o | ctl_i.crst;
        cp_tristate_o = pd_active_o | ctl_i.tri3;
        ld_reset_o    = pd_active_o;
        rf_en_o       = ~pd_active_o & (~ctl_i.mute | lock_det_i);
        cp_cur_o      = ctl_i.gain ? ctl_i.cur2 : ctl_i.cur1;
    end

    AST_PD_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        pd_active_o |-> (cnt_hold_o && cp_tristate_o && ld_reset_o && !rf_en_o)) else $error("pd"); // R7
    AST_MUTE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.mute && !lock_det_i) |-> !rf_en_o) else $error("mute"); // R11
    AST_TRI_BIT: assert property (@(posedge clk) disable iff (rst)
        ctl_i.tri3 |-> cp_tristate_o) else $error("tri"); // R12
endmodule

// File: rtl/synth_ctl_latch.sv
module synth_ctl_latch
    import sctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_i,
    input  logic       sdata_i,
    input  logic       le_i,
    input  logic       ce_i,
    input  logic       ref_pulse_i,
    input  logic       lock_det_i,
    output logic       pd_active_o,
    output logic       cnt_hold_o,
    output logic       cp_tristate_o,
    output logic       ld_reset_o,
    output logic       rf_en_o,
    output logic [2:0] cp_cur_o
);
    logic load;
    ctl_t ctl;
    ctl_t next_ctl;
    logic down;

    sctl_serial_in u_in (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdata_i(sdata_i),
        .le_i(le_i), .load_o(load), .ctl_o(ctl)
    );

    assign next_ctl = decode(u_in.sr_q);

    sctl_pd_seq u_pd (
        .clk(clk), .rst(rst), .load_i(load), .ctl_i(ctl),
        .next_ctl_i(next_ctl), .ref_pulse_i(ref_pulse_i), .down_o(down)
    );

    sctl_drive u_drv (
        .clk(clk), .rst(rst), .ce_i(ce_i), .down_i(down), .ctl_i(ctl),
        .lock_det_i(lock_det_i), .pd_active_o(pd_active_o),
        .cnt_hold_o(cnt_hold_o), .cp_tristate_o(cp_tristate_o),
        .ld_reset_o(ld_reset_o), .rf_en_o(rf_en_o), .cp_cur_o(cp_cur_o)
    );

    AST_CE_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        !ce_i |-> (pd_active_o && !rf_en_o)) else $error("ce"); // R6
endmodule

// File: tb/tb_synth_ctl_latch.sv
module tb_synth_ctl_latch;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdata = 1'b0, le = 1'b0, ce = 1'b1, refp = 1'b0, lock = 1'b0;
    logic pd, hold, tri_o, ldr, rfen;
    logic [2:0] cur;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    synth_ctl_latch dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .le_i(le),
        .ce_i(ce), .ref_pulse_i(refp), .lock_det_i(lock),
        .pd_active_o(pd), .cnt_hold_o(hold), .cp_tristate_o(tri_o),
        .ld_reset_o(ldr), .rf_en_o(rfen), .cp_cur_o(cur)
    );

    function automatic logic [23:0] mk(int c1, int c2, bit gain, bit mute, bit crst,
                                      bit tri3, bit pd1, bit pd2, int addr);
        logic [23:0] w = '0;
        w[16:14] = c1[2:0];
        w[19:17] = c2[2:0];
        w[10] = gain;
        w[11] = mute;
        w[4]  = crst;
        w[3]  = tri3;
        w[20] = pd1;
        w[21] = pd2;
        w[1:0] = addr[1:0];
        return w;
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic bit_in(bit b);
        @(negedge clk); sdata = b; sclk = 1'b0;
        @(negedge clk); sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
    endtask

    task automatic shift(logic [23:0] w);
        for (int i = 23; i >= 0; i--) bit_in(w[i]);
    endtask

    task automatic strobe();
        @(negedge clk); le = 1'b1;
        @(negedge clk); le = 1'b0;
    endtask

    task automatic write(logic [23:0] w);
        shift(w);
        strobe();
    endtask

    task automatic ref_edge();
        @(negedge clk); refp = 1'b1;
        @(negedge clk); refp = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R7 reset pd", pd, 0);
        chk("R7 reset rf", rfen, 1);
        chk("R12 reset tri", tri_o, 0);
        chk("R10 reset hold", hold, 0);
        chk("R9 reset cur", cur, 0);

        // R9 / R1: sweep of current codes and gain
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int g = 0; g < 2; g++) begin
                    write(mk(a, b, g[0], 0, 0, 0, 0, 0, 0));
                    chk("R9 cur", cur, (g != 0) ? b : a);
                end

        // R1: extra leading bits are dropped
        write(mk(5, 2, 0, 0, 0, 0, 0, 0, 0));
        for (int i = 0; i < 6; i++) bit_in(1'b1);
        shift(mk(3, 6, 1, 0, 0, 0, 0, 0, 0));
        strobe();
        chk("R1 last24", cur, 6);

        // R2: other addresses ignored
        for (int ad = 1; ad < 4; ad++) begin
            write(mk(1, 1, 0, 1, 1, 1, 1, 0, ad));
            chk("R2 cur", cur, 6);
            chk("R2 pd", pd, 0);
            chk("R2 tri", tri_o, 0);
        end

        // R3 immediate power-down, R7 outputs
        shift(mk(2, 4, 0, 0, 0, 0, 1, 0, 0));
        @(negedge clk); le = 1'b1;
        @(negedge clk);
        chk("R3 pd next clk", pd, 1);
        le = 1'b0;
        chk("R7 hold", hold, 1);
        chk("R7 tri", tri_o, 1);
        chk("R7 ldr", ldr, 1);
        chk("R7 rf", rfen, 0);

        // R8: loads accepted while down
        write(mk(7, 1, 0, 0, 0, 0, 1, 0, 0));
        chk("R8 cur while down", cur, 7);
        chk("R8 still down", pd, 1);

        // R5 exit
        write(mk(7, 1, 0, 0, 0, 0, 0, 0, 0));
        chk("R5 exit", pd, 0);

        // R4 synchronous power-down
        write(mk(0, 0, 0, 0, 0, 0, 1, 1, 0));
        chk("R4 armed not down", pd, 0);
        ref_edge();
        chk("R4 after 1 edge", pd, 0);
        ref_edge();
        chk("R4 after 2 edges", pd, 1);
        write(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R5 exit sync", pd, 0);

        // R4 restart on re-arm
        write(mk(0, 0, 0, 0, 0, 0, 1, 1, 0));
        ref_edge();
        write(mk(0, 0, 0, 0, 0, 0, 1, 1, 0));
        ref_edge();
        chk("R4 restart 1 edge", pd, 0);
        ref_edge();
        chk("R4 restart 2 edges", pd, 1);
        write(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));

        // R5 cancel pending
        write(mk(0, 0, 0, 0, 0, 0, 1, 1, 0));
        ref_edge();
        write(mk(0, 0, 0, 0, 0, 0, 0, 1, 0));
        ref_edge();
        ref_edge();
        chk("R5 cancel pending", pd, 0);

        // R6 chip enable
        @(negedge clk); ce = 1'b0;
        #1;
        chk("R6 pd", pd, 1);
        chk("R6 rf", rfen, 0);
        @(negedge clk); ce = 1'b1;
        #1;
        chk("R6 release", pd, 0);

        // R10 counter reset bit
        write(mk(0, 0, 0, 0, 1, 0, 0, 0, 0));
        chk("R10 hold", hold, 1);
        chk("R10 no pd", pd, 0);

        // R11 mute until lock
        write(mk(0, 0, 0, 1, 0, 0, 0, 0, 0));
        chk("R11 muted", rfen, 0);
        @(negedge clk); lock = 1'b1;
        #1;
        chk("R11 locked", rfen, 1);

        // R12 three-state bit
        write(mk(0, 0, 0, 0, 0, 1, 0, 0, 0));
        chk("R12 tri", tri_o, 1);
        chk("R12 no pd", pd, 0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hang exp=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule